// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Controller

This block connects a small CPU's I/O register space to a 512-byte nonvolatile data store. The store has its own address space, separate from data SRAM, and is modelled here as a register array with a write delay that a parameter sets. Software reaches the block through four byte registers: a low address byte, a high address byte, a data byte and a control byte. Every transfer moves exactly one byte.

A read strobe halts the CPU for a few cycles and then places the addressed byte in the data register. A write strobe halts the CPU for a shorter time and then runs a timed program cycle. Software can poll a busy flag to see when that cycle ends. A write is accepted only inside a short window that opens when software sets an enable bit, so a single stray store to the control register cannot change the store. An optional ready interrupt is raised while the controller is idle.

Top module: `nvm_port_ctrl`

## Requirements
- R1: Register select `io_sel` picks the register. 0 is the low address byte. 1 is the high address byte, with only bit 0 kept. 2 is the data byte. 3 is control. Control bits: bit 0 is the read strobe, bit 1 is the write strobe, bit 2 is the enable (arm) bit and bit 3 is the ready interrupt enable. On readback, control bit 1 shows busy, bit 2 shows that the window is open, bit 3 shows the interrupt enable, and the other bits read 0. Writes use `io_we`. Reads are combinational on `io_rdata`.
- R2: A read strobe on an idle controller drives `cpu_halt` high for exactly 4 cycles. The data register holds the byte at the current address in the first cycle after `cpu_halt` falls.
- R3: A write strobe that arrives within the 4 cycles after an enable write drives `cpu_halt` high for exactly 2 cycles and starts a write of the data byte to the current address.
- R4: A write strobe given without an open window is ignored: no halt, no busy, store unchanged. That includes a strobe 5 or more cycles after the enable write. Any write-strobe attempt closes the window.
- R5: A started write holds busy for WR_CYCLES cycles (16 by default), beginning in the cycle after the strobe. Once busy falls, the new byte can be read back.
- R6: While busy, read strobes, write strobes and writes to either address register are ignored.
- R7: The strobe bits clear themselves. After a read completes, control bit 0 reads 0.
- R8: `irq_ready` is high exactly when control bit 3 is set and the controller is neither busy nor halting the CPU.
- R9: Reset clears busy, the halt, the window, the interrupt enable and the address and data registers. It leaves the store contents unchanged.
- R10: All 9 address bits select distinct bytes. Addresses 0x0FF and 0x1FF are different locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_sel | input | 2 | Register select |
| io_we | input | 1 | Register write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Readback of the selected register |
| cpu_halt | output | 1 | Holds the CPU after an access |
| irq_ready | output | 1 | Ready interrupt request |

## Verification
The assertions check four things on every cycle. A halt never lasts longer than the longest stall. A write can only start while the window is open. Every write start comes with a halt. The address stays frozen while busy. The exact 4-cycle and 2-cycle stall lengths, the edges of the enable window, the busy duration, the read-back data and the retention of the store across reset depend on sequences of stimulus, so only the directed scenarios in the bench show them.

// File: rtl/nvm_port_ctrl.sv
module nvm_port_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int ARM_WIN   = 4,
  parameter int WR_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] io_sel,
  input  logic       io_we,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cpu_halt,
  output logic       irq_ready
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int HI_W      = ADDR_W - 8;
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int HC_W      = $clog2(STALL_MAX + 1);
  localparam int BC_W      = $clog2(WR_CYCLES + 1);
  localparam int AC_W      = $clog2(ARM_WIN + 1);

  logic [7:0]        store [DEPTH];
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic [7:0]        data_q, wr_buf;
  logic [HC_W-1:0]   halt_cnt;
  logic [BC_W-1:0]   busy_cnt;
  logic [AC_W-1:0]   arm_cnt;
  logic              rd_pend, irq_en;

  wire busy   = busy_cnt != '0;
  wire armed  = arm_cnt != '0;
  wire idle   = !busy && halt_cnt == '0;
  wire ctl_wr = io_we && io_sel == 2'd3;
  wire wr_go  = ctl_wr && io_wdata[1] && armed && idle;
  wire rd_go  = ctl_wr && !io_wdata[1] && io_wdata[0] && idle;
  wire rd_end = rd_pend && halt_cnt == HC_W'(1);
  wire commit = busy_cnt == BC_W'(1);

  assign cpu_halt  = halt_cnt != '0;
  assign irq_ready = irq_en && idle;

  always_comb begin
    case (io_sel)
      2'd0:    io_rdata = addr_q[7:0];
      2'd1:    io_rdata = 8'(addr_q[ADDR_W-1:8]);
      2'd2:    io_rdata = data_q;
      default: io_rdata = {4'b0, irq_en, armed, busy, 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      wr_addr  <= '0;
      wr_buf   <= '0;
      halt_cnt <= '0;
      busy_cnt <= '0;
      arm_cnt  <= '0;
      rd_pend  <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (io_we && io_sel == 2'd0 && !busy) addr_q[7:0] <= io_wdata;
      if (io_we && io_sel == 2'd1 && !busy) addr_q[ADDR_W-1:8] <= io_wdata[HI_W-1:0];

      if (rd_end)                        data_q <= store[addr_q];
      else if (io_we && io_sel == 2'd2)  data_q <= io_wdata;

      if (ctl_wr) irq_en <= io_wdata[3];

      if (ctl_wr && io_wdata[1])      arm_cnt <= '0;
      else if (ctl_wr && io_wdata[2]) arm_cnt <= AC_W'(ARM_WIN);
      else if (armed)                 arm_cnt <= arm_cnt - AC_W'(1);

      if (rd_go)         halt_cnt <= HC_W'(RD_STALL);
      else if (wr_go)    halt_cnt <= HC_W'(WR_STALL);
      else if (cpu_halt) halt_cnt <= halt_cnt - HC_W'(1);

      if (rd_go)       rd_pend <= 1'b1;
      else if (rd_end) rd_pend <= 1'b0;

      if (wr_go) begin
        busy_cnt <= BC_W'(WR_CYCLES);
        wr_addr  <= addr_q;
        wr_buf   <= data_q;
      end else if (busy) begin
        busy_cnt <= busy_cnt - BC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && commit) store[wr_addr] <= wr_buf;
  end

  logic [HC_W:0] halt_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_run <= '0;
    else if (cpu_halt) halt_run <= halt_run + 1'b1;
    else               halt_run <= '0;
  end

  // R2
  halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> halt_run < (HC_W+1)'(STALL_MAX));

  // R4
  arm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  // R3
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cpu_halt);

  // R6
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
endmodule

// File: tb/nvm_port_ctrl_test.sv
`timescale 1ns/1ps
module nvm_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] io_sel = 2'd0;
  logic       io_we = 1'b0;
  logic [7:0] io_wdata = 8'd0;
  logic [7:0] io_rdata;
  logic       cpu_halt, irq_ready;
  int checks = 0, failures = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  nvm_port_ctrl uut (.clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_halt(cpu_halt), .irq_ready(irq_ready));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    io_sel = s; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
    io_sel = s; #1; d = io_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    bus_wr(2'd0, 8'(a)); bus_wr(2'd1, 8'(a >> 8));
  endtask

  task automatic mem_write(input int a, input logic [7:0] d);
    set_addr(a); bus_wr(2'd2, d);
    bus_wr(2'd3, 8'h04); bus_wr(2'd3, 8'h02);
    idle(20);
  endtask

  task automatic mem_read(input int a, output logic [7:0] d);
    set_addr(a); bus_wr(2'd3, 8'h01);
    idle(4); rd_reg(2'd2, d);
  endtask

  task automatic t_reset;
    check("R9 halt after reset", cpu_halt, 0);
    check("R9 irq after reset", irq_ready, 0);
    rd_reg(2'd3, v); check("R9 control after reset", v, 0);
    rd_reg(2'd0, v); check("R9 addr after reset", v, 0);
    rd_reg(2'd2, v); check("R9 data after reset", v, 0);
  endtask

  task automatic t_regs;
    bus_wr(2'd0, 8'hA5); bus_wr(2'd1, 8'hFF); bus_wr(2'd2, 8'h3C);
    rd_reg(2'd0, v); check("R1 addr low", v, 8'hA5);
    rd_reg(2'd1, v); check("R1 addr high keeps bit0", v, 8'h01);
    rd_reg(2'd2, v); check("R1 data reg", v, 8'h3C);
    bus_wr(2'd3, 8'h04);
    rd_reg(2'd3, v); check("R1 window flag", v, 8'h04);
    idle(5);
    rd_reg(2'd3, v); check("R1 window closed", v, 8'h00);
  endtask

  task automatic t_write_timing;
    set_addr(12'h012); bus_wr(2'd2, 8'h5A);
    bus_wr(2'd3, 8'h04); bus_wr(2'd3, 8'h02);
    check("R3 halt cycle1", cpu_halt, 1);
    rd_reg(2'd3, v); check("R5 busy flag", v, 8'h02);
    idle(1); check("R3 halt cycle2", cpu_halt, 1);
    idle(1); check("R3 halt ends", cpu_halt, 0);
    idle(13); rd_reg(2'd3, v); check("R5 busy at cycle 15", v, 8'h02);
    idle(1);  rd_reg(2'd3, v); check("R5 idle at cycle 16", v, 8'h00);
  endtask

  task automatic t_read_timing;
    set_addr(12'h012); bus_wr(2'd3, 8'h01);
    for (int i = 0; i < 4; i++) check("R2 read halt", cpu_halt, 1);
    idle(1); check("R2 halt c2", cpu_halt, 1);
    idle(2); check("R2 halt c4", cpu_halt, 1);
    idle(1); check("R2 halt ends", cpu_halt, 0);
    rd_reg(2'd2, v); check("R2 read data", v, 8'h5A);
    rd_reg(2'd3, v); check("R7 strobe cleared", v, 8'h00);
  endtask

  task automatic t_unarmed;
    set_addr(12'h012); bus_wr(2'd2, 8'h11); bus_wr(2'd3, 8'h02);
    check("R4 no halt unarmed", cpu_halt, 0);
    rd_reg(2'd3, v); check("R4 no busy unarmed", v, 8'h00);
    bus_wr(2'd3, 8'h04); idle(4); bus_wr(2'd3, 8'h02);
    check("R4 late strobe no halt", cpu_halt, 0);
    mem_read(12'h012, v); check("R4 store unchanged", v, 8'h5A);
    set_addr(12'h020); bus_wr(2'd2, 8'h77);
    bus_wr(2'd3, 8'h04); idle(3); bus_wr(2'd3, 8'h02);
    check("R3 last window cycle accepted", cpu_halt, 1);
    idle(20);
    mem_read(12'h020, v); check("R5 readback after busy", v, 8'h77);
  endtask

  task automatic t_busy_ignore;
    set_addr(12'h030); bus_wr(2'd2, 8'h42);
    bus_wr(2'd3, 8'h04); bus_wr(2'd3, 8'h02);
    idle(2);
    bus_wr(2'd3, 8'h01); check("R6 read ignored while busy", cpu_halt, 0);
    bus_wr(2'd0, 8'h55); bus_wr(2'd1, 8'h01);
    rd_reg(2'd0, v); check("R6 addr low frozen", v, 8'h30);
    rd_reg(2'd1, v); check("R6 addr high frozen", v, 8'h00);
    bus_wr(2'd3, 8'h04); bus_wr(2'd3, 8'h02);
    check("R6 write ignored while busy", cpu_halt, 0);
    idle(20);
    bus_wr(2'd3, 8'h02);
    check("R4 window closed by failed attempt", cpu_halt, 0);
    mem_read(12'h030, v); check("R6 first write landed", v, 8'h42);
  endtask

  task automatic t_addr_span;
    mem_write(12'h000, 8'hC3); mem_write(12'h0FF, 8'h5C); mem_write(12'h1FF, 8'h3C);
    mem_read(12'h000, v); check("R10 addr 0x000", v, 8'hC3);
    mem_read(12'h0FF, v); check("R10 addr 0x0FF", v, 8'h5C);
    mem_read(12'h1FF, v); check("R10 addr 0x1FF", v, 8'h3C);
  endtask

  task automatic t_irq;
    bus_wr(2'd3, 8'h08); check("R8 irq when idle", irq_ready, 1);
    set_addr(12'h040); bus_wr(2'd2, 8'h0F);
    bus_wr(2'd3, 8'h0C); bus_wr(2'd3, 8'h0A);
    check("R8 irq low while busy", irq_ready, 0);
    idle(20); check("R8 irq back when idle", irq_ready, 1);
    bus_wr(2'd3, 8'h00); check("R8 irq disabled", irq_ready, 0);
  endtask

  task automatic t_reset_keep;
    mem_write(12'h100, 8'h99);
    bus_wr(2'd3, 8'h0C);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    rd_reg(2'd3, v); check("R9 window and irq cleared", v, 8'h00);
    bus_wr(2'd3, 8'h02); check("R9 no write after reset", cpu_halt, 0);
    mem_read(12'h100, v); check("R9 store kept", v, 8'h99);
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    t_reset();
    t_regs();
    t_write_timing();
    t_read_timing();
    t_unarmed();
    t_busy_ignore();
    t_addr_span();
    t_irq();
    t_reset_keep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule